// File: doc/BRIEF.md
# Transmit Empty Interrupt Generator

This block sits beside the transmit FIFO of a FIFO-mode serial transmitter. It watches the FIFO occupancy and host accesses. From them it produces the holding-empty status bit and the transmit-empty interrupt request. When the FIFO empties after a burst of two or more bytes, the status rises at once. When the FIFO has only ever held a single byte since the status last rose, the status is held back for one character time less the final stop bit. This paces single-byte traffic.

The held-back timing applies only after the transmit interrupt has been enabled with the FIFO switched on. Turning the FIFO off removes that condition. A host write to the holding register removes a pending request, and so does a read of the interrupt identification register. A FIFO-enable change event raises the request at once when the status is already set. The FIFO storage, the shift register and the ranking against other interrupt sources all sit outside this block.

Top module: `txe_irq_gen`

## Requirements
- R1: After reset, `thre` is 1 and `tx_irq` is 0.
- R2: When `fifo_cnt` is nonzero at a clock edge, `thre` is 0 after that edge.
- R3: When `fifo_cnt` drops from nonzero to 0 and the delay condition does not hold, `thre` is 1 after that same edge. The delay condition does not hold when occupancy reached 2 or more since `thre` last rose, or when the block is not armed.
- R4: When `fifo_cnt` drops to 0, the block is armed and occupancy stayed below 2 since `thre` last rose, `thre` stays 0. It becomes 1 at the edge of the (`frame_bits` − 1)-th `baud_tick` that follows, where `frame_bits` is the character length in bit times.
- R5: A `thr_wr` pulse or a nonzero `fifo_cnt` during the hold-back cancels it. The next drop to 0 starts a full new hold-back.
- R6: When `thre` rises while `fifo_en` and `tx_ie` are both 1, `tx_irq` is 1 from the next cycle.
- R7: A `thr_wr` or `iir_rd` pulse makes `tx_irq` 0 after that edge. A clear wins over a set in the same cycle.
- R8: A `fifo_en_chg` pulse while `thre` is 1 and both enables are 1 raises `tx_irq` after that edge, with no hold-back.
- R9: While either enable is 0, `tx_irq` is 0. A `thre` rise seen while the interrupt is disabled is not kept, so `tx_irq` stays 0 when the interrupt is enabled later.
- R10: The block becomes armed at the first edge where `fifo_en` and `tx_ie` are both 1. It is disarmed while `fifo_en` is 0, and a disarmed single-byte drop follows R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_cnt | input | CNT_W | Transmit FIFO occupancy |
| thr_wr | input | 1 | Host write strobe to the holding register |
| iir_rd | input | 1 | Host read strobe of the interrupt identification register |
| fifo_en | input | 1 | FIFO enable bit |
| fifo_en_chg | input | 1 | One-cycle pulse when the FIFO enable bit is written with a change |
| tx_ie | input | 1 | Transmit interrupt enable bit |
| baud_tick | input | 1 | One pulse per bit time |
| frame_bits | input | FRAME_W | Character length in bit times, including start, parity and stop bits |
| thre | output | 1 | Holding-empty status |
| tx_irq | output | 1 | Transmit-empty interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-entry FIFO, which gives a 5-bit occupancy, and a 4-bit frame length. It runs 10-bit and 7-bit frames. The two frames give hold-back windows of 9 and 6 ticks, and the bench checks the tick one short of the window as well as the last tick. With these values it reaches cancellation partway through the window, a clear that lands on the same edge as a status rise, and disarming through the FIFO-enable bit.

// File: rtl/txe_pkg.sv
package txe_pkg;

    localparam int FRAME_W_DEF = 4;

    typedef enum logic [1:0] {
        EV_NONE      = 2'd0,
        EV_IMMEDIATE = 2'd1,
        EV_DEFER     = 2'd2
    } empty_ev_e;

    function automatic empty_ev_e classify_empty(input logic drop, input logic defer);
        if (!drop)
            return EV_NONE;
        else if (defer)
            return EV_DEFER;
        else
            return EV_IMMEDIATE;
    endfunction

endpackage

// File: rtl/txe_hist.sv
module txe_hist #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] fifo_cnt,
    input  logic             thre_set,
    input  logic             fifo_en,
    input  logic             tx_ie,
    output logic             multi,
    output logic             armed
);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            multi <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (fifo_cnt >= TWO)
                multi <= 1'b1;
            else if (thre_set)
                multi <= 1'b0;

            if (!fifo_en)
                armed <= 1'b0;
            else if (tx_ie)
                armed <= 1'b1;
        end
    end

    assert_multi_seen_R3: assert property (@(posedge clk) disable iff (rst)
        (fifo_cnt >= TWO) |=> multi);

    assert_disarm_R10: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |=> !armed);

endmodule

// File: rtl/txe_delay.sv
module txe_delay #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         cancel,
    input  logic         tick,
    input  logic [W-1:0] load,
    output logic         busy,
    output logic         done
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;

    assign done = busy && tick && !cancel && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (cancel) begin
            busy <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= load;
        end else if (busy && tick) begin
            if (cnt == ONE)
                busy <= 1'b0;
            else
                cnt <= cnt - ONE;
        end
    end

    assert_hold_count_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !cancel && !start && !tick) |=> ($stable(cnt) && busy));

    assert_cancel_R5: assert property (@(posedge clk) disable iff (rst)
        cancel |=> !busy);

endmodule

// File: rtl/txe_irq.sv
module txe_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr,
    input  logic en,
    output logic irq
);
    logic pend;

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (clr)
            pend <= 1'b0;
        else if (set_evt && en)
            pend <= 1'b1;
    end

    assign irq = pend && en;

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> !irq);

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!en && !pend) |=> !pend);

endmodule

// File: rtl/txe_irq_gen.sv
module txe_irq_gen
    import txe_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int FRAME_W    = FRAME_W_DEF,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   fifo_cnt,
    input  logic               thr_wr,
    input  logic               iir_rd,
    input  logic               fifo_en,
    input  logic               fifo_en_chg,
    input  logic               tx_ie,
    input  logic               baud_tick,
    input  logic [FRAME_W-1:0] frame_bits,
    output logic               thre,
    output logic               tx_irq
);
    logic [CNT_W-1:0]   cnt_q;
    logic               fifo_empty;
    logic               drop;
    logic               multi;
    logic               armed;
    logic               dly_busy;
    logic               dly_done;
    logic               thre_set;
    logic               irq_set;
    logic [FRAME_W-1:0] hold_len;
    empty_ev_e          ev;

    assign fifo_empty = (fifo_cnt == '0);
    assign drop       = (cnt_q != '0) && fifo_empty;
    assign ev         = classify_empty(drop, armed && !multi);
    assign hold_len   = frame_bits - FRAME_W'(1);
    assign thre_set   = fifo_empty && ((ev == EV_IMMEDIATE) || dly_done);
    assign irq_set    = (thre_set && !thre) || (fifo_en_chg && thre);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            thre  <= 1'b1;
        end else begin
            cnt_q <= fifo_cnt;
            if (!fifo_empty)
                thre <= 1'b0;
            else if (thre_set)
                thre <= 1'b1;
        end
    end

    txe_hist #(.CNT_W(CNT_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .fifo_cnt (fifo_cnt),
        .thre_set (thre_set),
        .fifo_en  (fifo_en),
        .tx_ie    (tx_ie),
        .multi    (multi),
        .armed    (armed)
    );

    txe_delay #(.W(FRAME_W)) u_delay (
        .clk    (clk),
        .rst    (rst),
        .start  (ev == EV_DEFER),
        .cancel (thr_wr || !fifo_empty),
        .tick   (baud_tick),
        .load   (hold_len),
        .busy   (dly_busy),
        .done   (dly_done)
    );

    txe_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_evt (irq_set),
        .clr     (thr_wr || iir_rd),
        .en      (fifo_en && tx_ie),
        .irq     (tx_irq)
    );

    assert_nonempty_low_R2: assert property (@(posedge clk) disable iff (rst)
        (fifo_cnt != '0) |=> !thre);

    assert_rise_only_empty_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(thre) |-> $past(fifo_cnt == '0));

    assert_defer_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_DEFER && !thr_wr) |=> (!thre && dly_busy));

    assert_write_clears_R7: assert property (@(posedge clk) disable iff (rst)
        thr_wr |=> !tx_irq);

    assert_irq_needs_en_R9: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> (fifo_en && tx_ie));

endmodule

// File: tb/txe_irq_gen_tb.sv
module txe_irq_gen_tb;
    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CNT_W-1:0] fifo_cnt = '0;
    logic thr_wr = 1'b0, iir_rd = 1'b0, fifo_en = 1'b0, fifo_en_chg = 1'b0;
    logic tx_ie = 1'b0, baud_tick = 1'b0;
    logic [3:0] frame_bits = 4'd10;
    logic thre, tx_irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    txe_irq_gen u_dut (
        .clk(clk), .rst(rst), .fifo_cnt(fifo_cnt), .thr_wr(thr_wr), .iir_rd(iir_rd),
        .fifo_en(fifo_en), .fifo_en_chg(fifo_en_chg), .tx_ie(tx_ie),
        .baud_tick(baud_tick), .frame_bits(frame_bits), .thre(thre), .tx_irq(tx_irq)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        thr_wr = 0; iir_rd = 0; fifo_en_chg = 0; baud_tick = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            baud_tick = 1;
            step();
        end
    endtask

    task automatic single_write();
        thr_wr = 1; fifo_cnt = 1;
        step();
        fifo_cnt = 0;
        step();
    endtask

    task automatic t_reset();
        check("R1", "thre after reset", thre, 1'b1);
        check("R1", "irq after reset", tx_irq, 1'b0);
    endtask

    task automatic t_enable();
        fifo_en = 1; tx_ie = 1; fifo_en_chg = 1;
        step();
        check("R8", "irq on enable change", tx_irq, 1'b1);
        iir_rd = 1;
        step();
        check("R7", "irq cleared by id read", tx_irq, 1'b0);
    endtask

    task automatic t_single();
        thr_wr = 1; fifo_cnt = 1;
        step();
        check("R2", "thre low with data", thre, 1'b0);
        fifo_cnt = 0;
        step();
        check("R4", "thre held after drop", thre, 1'b0);
        ticks(8);
        check("R4", "thre held one tick short", thre, 1'b0);
        ticks(1);
        check("R4", "thre after 9 ticks", thre, 1'b1);
        check("R6", "irq on delayed rise", tx_irq, 1'b1);
        iir_rd = 1;
        step();
        check("R7", "irq cleared by id read", tx_irq, 1'b0);
    endtask

    task automatic t_burst();
        thr_wr = 1; fifo_cnt = 1; step();
        thr_wr = 1; fifo_cnt = 2; step();
        fifo_cnt = 1; step();
        fifo_cnt = 0; step();
        check("R3", "immediate thre after burst", thre, 1'b1);
        check("R6", "irq after burst", tx_irq, 1'b1);
        single_write();
        check("R7", "irq cleared by write", tx_irq, 1'b0);
        check("R4", "burst history cleared", thre, 1'b0);
        ticks(9);
        check("R4", "thre after refill delay", thre, 1'b1);
        iir_rd = 1; step();
    endtask

    task automatic t_cancel();
        single_write();
        ticks(4);
        thr_wr = 1; fifo_cnt = 1; step();
        check("R5", "thre low after cancel write", thre, 1'b0);
        ticks(12);
        check("R5", "cancelled delay never fires", thre, 1'b0);
        fifo_cnt = 0; step();
        ticks(8);
        check("R5", "restart is full length", thre, 1'b0);
        ticks(1);
        check("R5", "restarted delay completes", thre, 1'b1);
        iir_rd = 1; step();
    endtask

    task automatic t_disabled();
        tx_ie = 0;
        single_write();
        ticks(9);
        check("R9", "thre rises while irq off", thre, 1'b1);
        check("R9", "no irq while disabled", tx_irq, 1'b0);
        tx_ie = 1; step();
        check("R9", "rise not kept for later enable", tx_irq, 1'b0);
    endtask

    task automatic t_disarm();
        fifo_en = 0; step();
        single_write();
        check("R10", "disarmed drop is immediate", thre, 1'b1);
        check("R9", "no irq with FIFO off", tx_irq, 1'b0);
        fifo_en = 1; fifo_en_chg = 1; step();
        check("R8", "irq on FIFO re-enable", tx_irq, 1'b1);
        iir_rd = 1; step();
        single_write();
        check("R10", "re-armed drop is delayed", thre, 1'b0);
        ticks(9);
        check("R10", "re-armed delay ends", thre, 1'b1);
        iir_rd = 1; step();
    endtask

    task automatic t_short_frame();
        frame_bits = 4'd7;
        single_write();
        ticks(5);
        check("R4", "7-bit frame one tick short", thre, 1'b0);
        baud_tick = 1; iir_rd = 1;
        step();
        check("R4", "7-bit frame after 6 ticks", thre, 1'b1);
        check("R7", "clear wins over set", tx_irq, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        step();
        t_reset();
        t_enable();
        t_single();
        t_burst();
        t_cancel();
        t_disabled();
        t_disarm();
        t_short_frame();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule